// File: doc/BRIEF.md
# Dual-Port Hardware Semaphore Bank

This block holds a small bank of hardware lock flags that two independent agents, called left and right, use to agree on who may touch a shared resource. Each agent has its own port with a select, a flag address, a write strobe, a one-bit write datum, an output enable and a wide read-data bus. The block sits in its own address space, so it never overlaps the data memory it guards. Only the lowest address bits pick a flag. Every other address bit is ignored.

An agent takes a token by writing 0 to a flag and gives it back by writing 1. It then reads the flag to see whether it won. Each flag keeps one request latch per side and an owner register. If a side asks for a token the other side holds, its request is parked. The token moves to that side the moment the owner lets go. When both sides ask for the same free flag in the same cycle, a tie breaker grants exactly one of them. A read is captured into the port's output register on its first active cycle and held until the read ends, so the other side's writes cannot change it partway through.

Top module: `sem_bank`

## Requirements
- R1: While `rst_n` is low on a clock edge, every request latch on both sides is cleared and every flag becomes free. Both `l_rdata` and `r_rdata` read all ones, and any write presented in a reset cycle is dropped.
- R2: The flag index is `addr[2:0]` with the default `NUM_SEM` of 8. Address bits above the index have no effect on which flag is written or read.
- R3: A write is a cycle with `sel` and `wr` both high. `wdata` = 0 sets that side's request for the addressed flag, and `wdata` = 1 clears it.
- R4: A side whose request reaches a free flag first becomes the owner. It then reads 0, the other side reads 1, and ownership stays put until the owner writes 1.
- R5: A 0 written by the non-owner is held as a pending request. When the owner writes 1, ownership moves in that same edge to the pending side, which then keeps it until it writes 1 itself.
- R6: When the owner writes 1 and the other side has nothing pending, the flag becomes free and reads as all ones on both ports.
- R7: A tie is both sides requesting one free flag in the same cycle. A tie grants exactly one side. With `TIE_ALT` = 1 (the default), each flag's first tie after reset goes to left and later ties on that flag alternate. With `TIE_ALT` = 0, left always wins.
- R8: A read is a cycle with `sel` and `oe` high and `wr` low. Read data appears in the cycle after the read starts. The flag's view for that side is copied into all `DATA_W` bits, giving all zeros when that side owns the flag and all ones otherwise. A port reads all ones from the cycle after its read ends.
- R9: The value captured on the first cycle of a read is held for every remaining cycle of that read, even if ownership changes meanwhile.
- R10: A side that writes 0 to a flag it already owns keeps ownership unchanged. A side that writes 1 with no request set causes no change.
- R11: Two reads of the same flag started in the same cycle never both return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for all state |
| rst_n | input | 1 | Synchronous active-low reset |
| l_sel | input | 1 | Left port semaphore select |
| l_addr | input | ADDR_W | Left port address, low bits pick the flag |
| l_wr | input | 1 | Left port write strobe |
| l_wdata | input | 1 | Left write datum: 0 request, 1 release |
| l_oe | input | 1 | Left port output enable |
| l_rdata | output | DATA_W | Left read data, flag view replicated |
| r_sel | input | 1 | Right port semaphore select |
| r_addr | input | ADDR_W | Right port address, low bits pick the flag |
| r_wr | input | 1 | Right port write strobe |
| r_wdata | input | 1 | Right write datum: 0 request, 1 release |
| r_oe | input | 1 | Right port output enable |
| r_rdata | output | DATA_W | Right read data, flag view replicated |

## Verification
A lost or stuck pending request only shows up at the ports when the owner releases. The next read on the waiting side then returns all ones instead of all zeros. A corrupted owner register shows up sooner: the very next read on either side returns the wrong value, or both sides see a zero at once. The bench therefore reads back both sides after every request, release and tie, and runs a read that overlaps a handoff to expose any capture register that tracks the live flag.

// File: rtl/sem_pkg.sv
// Package: shared types for the dual-port semaphore bank.
// Assumes: two ports only, so an owner fits in a small enum.
package sem_pkg;

    // Owner of one flag; NONE means the token is free.
    typedef enum logic [1:0] {
        OWN_NONE  = 2'b00,
        OWN_LEFT  = 2'b01,
        OWN_RIGHT = 2'b10
    } owner_e;

    // Per-flag command from one port for one cycle.
    typedef struct packed {
        logic set;   // write of 0: raise request
        logic clr;   // write of 1: drop request
    } flag_cmd_t;

endpackage

// File: rtl/sem_port_decode.sv
// Module: sem_port_decode
// Turns one port's pins into per-flag request commands and a read strobe.
// Assumes NUM_SEM is a power of two and ADDR_W is wider than the index.
module sem_port_decode
    import sem_pkg::*;
#(
    parameter int ADDR_W  = 12,
    parameter int NUM_SEM = 8,
    localparam int IDX_W  = $clog2(NUM_SEM)
) (
    input  logic              sel,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr,
    input  logic              wdata,
    input  logic              oe,
    output flag_cmd_t         cmd [NUM_SEM],
    output logic              rd_act,
    output logic [IDX_W-1:0]  rd_idx
);

    logic             wr_hit;
    logic [IDX_W-1:0] idx;
    logic             addr_hi_unused;

    // Index is the low address bits; upper bits are deliberately dropped.
    assign idx            = addr[IDX_W-1:0];
    assign addr_hi_unused = ^addr[ADDR_W-1:IDX_W];
    assign wr_hit         = sel && wr;

    // Read is active when selected with output enable and no write.
    assign rd_act = sel && oe && !wr;
    assign rd_idx = idx;

    // One command slot per flag, chosen by the decoded index.
    for (genvar k = 0; k < NUM_SEM; k++) begin : g_cmd
        assign cmd[k].set = wr_hit && (idx == IDX_W'(k)) && !wdata;
        assign cmd[k].clr = wr_hit && (idx == IDX_W'(k)) &&  wdata;
    end

endmodule

// File: rtl/sem_flag.sv
// Module: sem_flag
// One semaphore: a request latch per side plus an owner register.
// The owner keeps the token while its latch is set; on release a parked
// request from the other side takes over in the same edge.
// Assumes set and clr from one side are never both high.
module sem_flag
    import sem_pkg::*;
#(
    parameter bit TIE_ALT = 1'b1
) (
    input  logic      clk,
    input  logic      rst_n,
    input  flag_cmd_t l_cmd,
    input  flag_cmd_t r_cmd,
    output logic      own_l,
    output logic      own_r,
    output logic      req_l,
    output logic      req_r
);

    logic   req_l_q, req_r_q, req_l_d, req_r_d;
    owner_e owner_q, owner_d;
    logic   tie_q;      // 1: next tie goes to right
    logic   tie_hit;    // a tie is resolved this cycle

    // Next value of each side's request latch.
    always_comb begin
        req_l_d = l_cmd.set ? 1'b1 : (l_cmd.clr ? 1'b0 : req_l_q);
        req_r_d = r_cmd.set ? 1'b1 : (r_cmd.clr ? 1'b0 : req_r_q);
    end

    // Ownership: keep, hand off to a pending side, or grant a free flag.
    always_comb begin
        owner_d = owner_q;
        tie_hit = 1'b0;
        unique case (owner_q)
            OWN_LEFT:  owner_d = req_l_d ? OWN_LEFT  : (req_r_d ? OWN_RIGHT : OWN_NONE);
            OWN_RIGHT: owner_d = req_r_d ? OWN_RIGHT : (req_l_d ? OWN_LEFT  : OWN_NONE);
            default: begin
                if (req_l_d && req_r_d) begin
                    tie_hit = 1'b1;
                    owner_d = tie_q ? OWN_RIGHT : OWN_LEFT;
                end else if (req_l_d) begin
                    owner_d = OWN_LEFT;
                end else if (req_r_d) begin
                    owner_d = OWN_RIGHT;
                end else begin
                    owner_d = OWN_NONE;
                end
            end
        endcase
    end

    // State registers for latches and owner.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_l_q <= 1'b0;
            req_r_q <= 1'b0;
            owner_q <= OWN_NONE;
        end else begin
            req_l_q <= req_l_d;
            req_r_q <= req_r_d;
            owner_q <= owner_d;
        end
    end

    // Tie-break variant picked by parameter.
    if (TIE_ALT) begin : g_tie_alt
        // Alternating winner: flip after each resolved tie.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                tie_q <= 1'b0;
            end else if (tie_hit) begin
                tie_q <= !tie_q;
            end
        end
    end else begin : g_tie_fixed
        assign tie_q = 1'b0;
    end

    assign own_l = (owner_q == OWN_LEFT);
    assign own_r = (owner_q == OWN_RIGHT);
    assign req_l = req_l_q;
    assign req_r = req_r_q;

endmodule

// File: rtl/sem_read_port.sv
// Module: sem_read_port
// Output register of one port. Captures the addressed flag on the first
// active read cycle, holds it while the read stays active, and returns to
// all ones when idle.
// Assumes own_vec is this side's ownership view (1 = this side owns).
module sem_read_port #(
    parameter int NUM_SEM = 8,
    parameter int DATA_W  = 36,
    localparam int IDX_W  = $clog2(NUM_SEM)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               rd_act,
    input  logic [IDX_W-1:0]   rd_idx,
    input  logic [NUM_SEM-1:0] own_vec,
    output logic [DATA_W-1:0]  rdata
);

    logic act_q;

    // Capture on read start, hold during read, park at all ones otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_q <= 1'b0;
            rdata <= '1;
        end else begin
            act_q <= rd_act;
            if (rd_act && !act_q) begin
                rdata <= {DATA_W{!own_vec[rd_idx]}};
            end else if (!rd_act) begin
                rdata <= '1;
            end
        end
    end

endmodule

// File: rtl/sem_bank.sv
// Module: sem_bank (top)
// Bank of NUM_SEM dual-port semaphore flags. Each port decodes its own
// commands; every flag arbitrates between the two sides; each port owns
// a capture register for reads.
// Assumes a single clock and synchronous active-low reset.
module sem_bank
    import sem_pkg::*;
#(
    parameter int ADDR_W  = 12,
    parameter int DATA_W  = 36,
    parameter int NUM_SEM = 8,
    parameter bit TIE_ALT = 1'b1,
    localparam int IDX_W  = $clog2(NUM_SEM)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              l_sel,
    input  logic [ADDR_W-1:0] l_addr,
    input  logic              l_wr,
    input  logic              l_wdata,
    input  logic              l_oe,
    output logic [DATA_W-1:0] l_rdata,
    input  logic              r_sel,
    input  logic [ADDR_W-1:0] r_addr,
    input  logic              r_wr,
    input  logic              r_wdata,
    input  logic              r_oe,
    output logic [DATA_W-1:0] r_rdata
);

    flag_cmd_t          l_cmd [NUM_SEM];
    flag_cmd_t          r_cmd [NUM_SEM];
    logic               l_rd_act, r_rd_act;
    logic [IDX_W-1:0]   l_rd_idx, r_rd_idx;
    logic [NUM_SEM-1:0] own_l_vec, own_r_vec;
    logic [NUM_SEM-1:0] req_l_vec, req_r_vec;

    // Left port decode.
    sem_port_decode #(.ADDR_W(ADDR_W), .NUM_SEM(NUM_SEM)) u_dec_l (
        .sel(l_sel), .addr(l_addr), .wr(l_wr), .wdata(l_wdata), .oe(l_oe),
        .cmd(l_cmd), .rd_act(l_rd_act), .rd_idx(l_rd_idx)
    );

    // Right port decode.
    sem_port_decode #(.ADDR_W(ADDR_W), .NUM_SEM(NUM_SEM)) u_dec_r (
        .sel(r_sel), .addr(r_addr), .wr(r_wr), .wdata(r_wdata), .oe(r_oe),
        .cmd(r_cmd), .rd_act(r_rd_act), .rd_idx(r_rd_idx)
    );

    // One arbitrated flag per index.
    for (genvar k = 0; k < NUM_SEM; k++) begin : g_flag
        sem_flag #(.TIE_ALT(TIE_ALT)) u_flag (
            .clk(clk), .rst_n(rst_n),
            .l_cmd(l_cmd[k]), .r_cmd(r_cmd[k]),
            .own_l(own_l_vec[k]), .own_r(own_r_vec[k]),
            .req_l(req_l_vec[k]), .req_r(req_r_vec[k])
        );
    end

    // Left read capture.
    sem_read_port #(.NUM_SEM(NUM_SEM), .DATA_W(DATA_W)) u_rd_l (
        .clk(clk), .rst_n(rst_n), .rd_act(l_rd_act), .rd_idx(l_rd_idx),
        .own_vec(own_l_vec), .rdata(l_rdata)
    );

    // Right read capture.
    sem_read_port #(.NUM_SEM(NUM_SEM), .DATA_W(DATA_W)) u_rd_r (
        .clk(clk), .rst_n(rst_n), .rd_act(r_rd_act), .rd_idx(r_rd_idx),
        .own_vec(own_r_vec), .rdata(r_rdata)
    );

endmodule

// File: rtl/sem_bank_chk.sv
// Module: sem_bank_chk
// Temporal checks on the semaphore bank, attached by bind.
// Assumes the flag index is the low address bits.
module sem_bank_chk #(
    parameter int ADDR_W  = 12,
    parameter int DATA_W  = 36,
    parameter int NUM_SEM = 8,
    localparam int IDX_W  = $clog2(NUM_SEM)
) (
    input logic               clk,
    input logic               rst_n,
    input logic               l_sel,
    input logic [ADDR_W-1:0]  l_addr,
    input logic               l_wr,
    input logic               l_wdata,
    input logic               l_oe,
    input logic [DATA_W-1:0]  l_rdata,
    input logic               r_sel,
    input logic [ADDR_W-1:0]  r_addr,
    input logic               r_wr,
    input logic               r_wdata,
    input logic               r_oe,
    input logic [DATA_W-1:0]  r_rdata,
    input logic [NUM_SEM-1:0] own_l_vec,
    input logic [NUM_SEM-1:0] own_r_vec,
    input logic [NUM_SEM-1:0] req_l_vec,
    input logic [NUM_SEM-1:0] req_r_vec
);

    logic l_act, r_act;
    assign l_act = l_sel && l_oe && !l_wr;
    assign r_act = r_sel && r_oe && !r_wr;

    // R9: captured value stays put while a read continues.
    p_hold_l_r9: assert property (@(posedge clk) disable iff (!rst_n)
        l_act && $past(l_act) |=> $stable(l_rdata));
    p_hold_r_r9: assert property (@(posedge clk) disable iff (!rst_n)
        r_act && $past(r_act) |=> $stable(r_rdata));

    // R8: an idle port reads all ones.
    p_idle_l_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !l_act |=> (l_rdata == '1));
    p_idle_r_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !r_act |=> (r_rdata == '1));

    for (genvar k = 0; k < NUM_SEM; k++) begin : g_chk
        logic l_rel, r_rel, l_req, r_req;
        assign l_rel = l_sel && l_wr &&  l_wdata && (l_addr[IDX_W-1:0] == IDX_W'(k));
        assign r_rel = r_sel && r_wr &&  r_wdata && (r_addr[IDX_W-1:0] == IDX_W'(k));
        assign l_req = l_sel && l_wr && !l_wdata && (l_addr[IDX_W-1:0] == IDX_W'(k));
        assign r_req = r_sel && r_wr && !r_wdata && (r_addr[IDX_W-1:0] == IDX_W'(k));

        // R4: ownership survives anything but the owner's own release.
        p_keep_l_r4: assert property (@(posedge clk) disable iff (!rst_n)
            own_l_vec[k] && !l_rel |=> own_l_vec[k]);
        p_keep_r_r4: assert property (@(posedge clk) disable iff (!rst_n)
            own_r_vec[k] && !r_rel |=> own_r_vec[k]);

        // R5: release with a parked request hands the token over.
        p_handoff_l_r5: assert property (@(posedge clk) disable iff (!rst_n)
            own_l_vec[k] && l_rel && req_r_vec[k] |=> own_r_vec[k]);
        p_handoff_r_r5: assert property (@(posedge clk) disable iff (!rst_n)
            own_r_vec[k] && r_rel && req_l_vec[k] |=> own_l_vec[k]);

        // R6: release with nothing waiting frees the flag.
        p_free_l_r6: assert property (@(posedge clk) disable iff (!rst_n)
            own_l_vec[k] && l_rel && !req_r_vec[k] && !r_req |=> !own_l_vec[k] && !own_r_vec[k]);
        p_free_r_r6: assert property (@(posedge clk) disable iff (!rst_n)
            own_r_vec[k] && r_rel && !req_l_vec[k] && !l_req |=> !own_l_vec[k] && !own_r_vec[k]);
    end

endmodule

bind sem_bank sem_bank_chk #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_SEM(NUM_SEM)
) u_chk (.*);

// File: tb/tb_sem_bank.sv
// Scoreboard bench: driver tasks queue expected read data, a monitor
// compares each item in the cycle it falls due.
module tb_sem_bank;

    localparam int ADDR_W  = 12;
    localparam int DATA_W  = 36;
    localparam int NUM_SEM = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic l_sel, l_wr, l_wdata, l_oe, r_sel, r_wr, r_wdata, r_oe;
    logic [ADDR_W-1:0] l_addr, r_addr;
    logic [DATA_W-1:0] l_rdata, r_rdata;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    typedef struct {
        bit                port;   // 0 left, 1 right
        logic [DATA_W-1:0] exp;
        string             tag;
        int                due;
    } item_t;
    item_t q[$];

    sem_bank #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_SEM(NUM_SEM), .TIE_ALT(1'b1)) dut (
        .clk(clk), .rst_n(rst_n),
        .l_sel(l_sel), .l_addr(l_addr), .l_wr(l_wr), .l_wdata(l_wdata), .l_oe(l_oe), .l_rdata(l_rdata),
        .r_sel(r_sel), .r_addr(r_addr), .r_wr(r_wr), .r_wdata(r_wdata), .r_oe(r_oe), .r_rdata(r_rdata)
    );

    always #10 clk = !clk;
    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [DATA_W-1:0] view(input bit owned);
        return owned ? '0 : '1;
    endfunction

    task automatic check(input string tag, input logic [DATA_W-1:0] act, input logic [DATA_W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Monitor: compare every queued item in its due cycle.
    always @(negedge clk) begin
        while (q.size() > 0 && q[0].due <= cyc) begin
            item_t it;
            it = q.pop_front();
            if (it.due < cyc) check({it.tag, " stale"}, '0, '1);
            else check(it.tag, it.port ? r_rdata : l_rdata, it.exp);
        end
    end

    task automatic clr_all();
        l_sel = 0; l_wr = 0; l_wdata = 0; l_oe = 0; l_addr = '0;
        r_sel = 0; r_wr = 0; r_wdata = 0; r_oe = 0; r_addr = '0;
    endtask

    task automatic set_wr(input bit p, input logic [ADDR_W-1:0] a, input bit d);
        if (!p) begin l_sel = 1; l_wr = 1; l_addr = a; l_wdata = d; end
        else    begin r_sel = 1; r_wr = 1; r_addr = a; r_wdata = d; end
    endtask

    task automatic set_rd(input bit p, input logic [ADDR_W-1:0] a);
        if (!p) begin l_sel = 1; l_oe = 1; l_addr = a; end
        else    begin r_sel = 1; r_oe = 1; r_addr = a; end
    endtask

    task automatic push(input bit p, input bit owned, input string tag, input int due);
        item_t it;
        it.port = p; it.exp = view(owned); it.tag = tag; it.due = due;
        q.push_back(it);
    endtask

    // Single-cycle write on one port.
    task automatic wr(input bit p, input logic [ADDR_W-1:0] a, input bit d);
        @(negedge clk); clr_all(); set_wr(p, a, d);
        @(negedge clk); clr_all();
    endtask

    // Simultaneous write on both ports to one address.
    task automatic wr2(input logic [ADDR_W-1:0] a, input bit dl, input bit dr);
        @(negedge clk); clr_all(); set_wr(0, a, dl); set_wr(1, a, dr);
        @(negedge clk); clr_all();
    endtask

    // Read held n cycles; every held cycle plus the idle cycle after is checked.
    task automatic rd(input bit p, input logic [ADDR_W-1:0] a, input bit owned, input string tag, input int n);
        @(negedge clk); clr_all(); set_rd(p, a);
        for (int i = 1; i <= n; i++) push(p, owned, tag, cyc + i);
        for (int i = 0; i < n; i++) @(negedge clk);
        clr_all();
        push(p, 1'b0, "R8 idle all ones", cyc + 1);
    endtask

    // Both ports read one flag in the same cycle.
    task automatic rd2(input logic [ADDR_W-1:0] a, input bit own_l, input bit own_r, input string tag);
        @(negedge clk); clr_all(); set_rd(0, a); set_rd(1, a);
        push(0, own_l, {tag, " left"}, cyc + 1);
        push(1, own_r, {tag, " right"}, cyc + 1);
        @(negedge clk);
        checks++;
        if (l_rdata == '0 && r_rdata == '0) begin
            errors++;
            $display("FAIL R11 both zero actual=%h/%h expected=not both zero", l_rdata, r_rdata);
        end
        clr_all();
    endtask

    initial begin
        #(20 * 100000);
        checks++; errors++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        clr_all();
        repeat (2) @(negedge clk);
        set_wr(0, 12'h000, 1'b0);           // R1: dropped during reset
        @(negedge clk);
        clr_all(); rst_n = 1'b1;
        check("R1 reset left rdata", l_rdata, '1);
        check("R1 reset right rdata", r_rdata, '1);
        rd(0, 12'h000, 1'b0, "R1 write in reset ignored", 1);
        rd(1, 12'h000, 1'b0, "R1 flag0 free right", 1);

        // R2/R3/R4: upper address bits ignored, first requester owns.
        wr(0, 12'hF02, 1'b0);
        rd(0, 12'h002, 1'b1, "R2 R4 left owns flag2", 2);
        rd(1, 12'hA42, 1'b0, "R4 right sees one", 1);
        rd(1, 12'h003, 1'b0, "R2 flag3 untouched", 1);

        // R10: non-owner release without request is a no-op.
        wr(1, 12'h002, 1'b1);
        rd(0, 12'h002, 1'b1, "R10 stray release", 1);
        // R5: right parks a request.
        wr(1, 12'h002, 1'b0);
        rd(1, 12'h002, 1'b0, "R5 right pending reads one", 1);
        rd(0, 12'h002, 1'b1, "R4 right cannot steal", 1);
        // R10: owner re-request keeps it.
        wr(0, 12'h002, 1'b0);
        rd(0, 12'h002, 1'b1, "R10 re-request", 1);
        // R5: release hands off.
        wr(0, 12'h002, 1'b1);
        rd2(12'h002, 1'b0, 1'b1, "R5 handoff");
        // R6: release with nothing waiting.
        wr(1, 12'h002, 1'b1);
        rd2(12'h002, 1'b0, 1'b0, "R6 freed");
        wr(0, 12'h005, 1'b0);
        wr(0, 12'h005, 1'b1);
        rd2(12'h005, 1'b0, 1'b0, "R6 left request release");

        // R7: ties on flag3 alternate, starting with left.
        wr2(12'h003, 1'b0, 1'b0);
        rd2(12'h003, 1'b1, 1'b0, "R7 first tie left");
        wr(0, 12'h003, 1'b1);
        rd2(12'h003, 1'b0, 1'b1, "R5 loser gets token");
        wr(1, 12'h003, 1'b1);
        rd2(12'h003, 1'b0, 1'b0, "R6 tie flag freed");
        wr2(12'h003, 1'b0, 1'b0);
        rd2(12'h003, 1'b0, 1'b1, "R7 second tie right");
        wr(1, 12'h003, 1'b1);
        wr(0, 12'h003, 1'b1);
        rd2(12'h003, 1'b0, 1'b0, "R7 all released");

        // R9: left read started before a handoff keeps its captured ones.
        wr(1, 12'h006, 1'b0);
        wr(0, 12'h006, 1'b0);
        @(negedge clk); clr_all(); set_rd(0, 12'h006);
        for (int i = 1; i <= 4; i++) push(0, 1'b0, "R9 held through handoff", cyc + i);
        @(negedge clk); set_wr(1, 12'h006, 1'b1);
        @(negedge clk); r_sel = 0; r_wr = 0; r_wdata = 0; r_addr = '0;
        repeat (2) @(negedge clk);
        clr_all();
        rd(0, 12'h006, 1'b1, "R9 new read sees ownership", 1);
        rd(1, 12'h006, 1'b0, "R8 right replicated ones", 1);

        repeat (4) @(negedge clk);
        if (q.size() != 0) check("scoreboard drained", '0, '1);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule